// File: doc/BRIEF.md
# Prioritized External Interrupt Request Controller

This block collects six external interrupt request pins, qualifies them, and presents one prioritized request to a processor core. Each pin is set up by software to be sensed either by level or by rising edge. A level-sensed pin requests service for as long as its synchronized state is high. An edge-sensed pin records a qualified rising edge in a request latch, and that latch holds until software clears it.

Every pin has a 4-bit priority, and a priority of zero masks the pin completely. On every cycle the controller picks the pending pin with the highest priority, compares that level against the core's current 4-bit mask level, and registers three results: an interrupt request, the winning level and the winning source number. It also produces a wake-up indication for standby. Only the lower five pins can cause a wake-up, and only when their priority is above the mask. The core's mask level is an input only, and the controller never changes it.

Software reaches the controller through a small synchronous write port with a combinational read-back. The register map is: 0 = sense modes, 1 and 2 = priorities, 3 = request status and clear.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all priorities and sense modes read 0 (level sensing), the request register reads 0, and irq_req_o, irq_level_o, irq_src_o and wake_o are all 0.
- R2: Address 0 holds the sense modes, one bit per pin in bits 5..0, where 1 selects edge and 0 selects level. Address 1 holds the priorities of pins 0..3 in nibbles [3:0], [7:4], [11:8] and [15:12]. Address 2 holds the priorities of pins 4 and 5 in [3:0] and [7:4]. Every unused bit reads as 0.
- R3: For a level-sensed pin (active high), bit i of address 3 reads the pin's state two clock edges after the pin changes. The request is not latched, so it disappears when the pin falls.
- R4: For an edge-sensed pin, a rising edge that stays high for at least 2 clock cycles sets bit i of address 3 on the 4th edge after the pin rises. The bit stays set after the pin returns low.
- R5: A high pulse of only one clock cycle on an edge-sensed pin leaves its request bit at 0.
- R6: Writing address 3 clears each edge latch whose data bit is 0. Data bits that are 1 have no effect. A level-sensed bit keeps showing the live pin state.
- R7: When a qualified edge arrives in the same cycle as a clear write to its bit, the bit stays set.
- R8: A pin whose priority is 0 never wins and never raises a request.
- R9: Among pending pins with nonzero priority, the one with the highest priority wins. On a tie, the lower-numbered pin wins. irq_level_o and irq_src_o show the winner even when the request is not raised.
- R10: irq_req_o is 1 only when the winning priority is strictly greater than cpu_mask_i.
- R11: wake_o is 1 only when at least one of pins 0..4 is pending with a priority strictly greater than cpu_mask_i. Pin 5 never wakes.
- R12: Results are registered. A level pin change reaches the outputs on the 3rd edge, a qualified edge reaches them on the 5th edge, and a register write or mask change reaches them on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 6 | Asynchronous external request pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| cpu_mask_i | input | 4 | Core's current interrupt mask level |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_level_o | output | 4 | Priority of the winning pin |
| irq_src_o | output | 3 | Number of the winning pin |
| wake_o | output | 1 | Standby wake-up indication |

## Verification
Each pin change goes through a two-flop synchronizer. A level pin therefore shows in the read-back two edges after it is driven and at the outputs on the third edge. An edge pin needs two more edges for pulse qualification, so its latch is set on the fourth edge and the outputs follow on the fifth. The driver changes inputs at the falling edge, counts the exact rising edges to each result, and queues the expected value at that point. The monitor compares it just after the falling edge. At several of these points the bench also checks the cycle just before the result is due, where the old value must still be visible. This catches an added or a missing register stage.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int unsigned EIRQ_NUM_SRC = 6;
    localparam int unsigned EIRQ_PRIO_W  = 4;
    localparam int unsigned EIRQ_DATA_W  = 16;
    localparam int unsigned EIRQ_ADDR_W  = 2;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;
endpackage

// File: rtl/eirq_pin_qual.sv
module eirq_pin_qual #(
    parameter int unsigned NUM_SRC     = eirq_pkg::EIRQ_NUM_SRC,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] pin_i,
    output logic [NUM_SRC-1:0] sync_o,
    output logic [NUM_SRC-1:0] evt_o
);
    localparam int unsigned CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_PULSE);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
    } pin_st_t;

    pin_st_t st_q [NUM_SRC];
    pin_st_t st_d [NUM_SRC];

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            st_d[i]      = st_q[i];
            st_d[i].sync = {st_q[i].sync[SYNC_STAGES-2:0], pin_i[i]};
            sync_o[i]    = st_q[i].sync[SYNC_STAGES-1];
            if (!sync_o[i]) begin
                st_d[i].cnt = '0;
            end else if (st_q[i].cnt < CNT_SAT) begin
                st_d[i].cnt = st_q[i].cnt + 1'b1;
            end
            evt_o[i] = sync_o[i] && (st_q[i].cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    generate
        if (MIN_PULSE >= 2) begin : g_pulse_chk
            for (genvar g = 0; g < NUM_SRC; g++) begin : g_pin
                // R5
                pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    evt_o[g] |-> $past(sync_o[g]));
            end
        end
    endgenerate
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
    parameter int unsigned NUM_SRC = eirq_pkg::EIRQ_NUM_SRC,
    parameter int unsigned PRIO_W  = eirq_pkg::EIRQ_PRIO_W,
    parameter int unsigned DATA_W  = eirq_pkg::EIRQ_DATA_W,
    parameter int unsigned ADDR_W  = eirq_pkg::EIRQ_ADDR_W
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    input  logic [NUM_SRC-1:0]        sync_i,
    input  logic [NUM_SRC-1:0]        evt_i,
    output logic [NUM_SRC-1:0]        pend_o,
    output logic [NUM_SRC*PRIO_W-1:0] prio_o
);
    localparam int unsigned PPW        = DATA_W / PRIO_W;
    localparam int unsigned PRIO_WORDS = (NUM_SRC + PPW - 1) / PPW;
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
    localparam int unsigned       A_PRIO = 1;
    localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'(A_PRIO + PRIO_WORDS);

    typedef struct packed {
        logic [NUM_SRC-1:0]        edge_mode;
        logic [NUM_SRC*PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0]        latch;
    } reg_st_t;

    reg_st_t st_q, st_d;
    logic [NUM_SRC-1:0] clr_c;
    logic               wr_req_c;
    logic               wr_mode_c;

    assign wr_req_c  = we_i && (addr_i == A_REQ);
    assign wr_mode_c = we_i && (addr_i == A_MODE);

    always_comb begin
        st_d  = st_q;
        clr_c = '0;
        if (wr_mode_c) begin
            st_d.edge_mode = wdata_i[NUM_SRC-1:0];
        end
        if (we_i) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (addr_i == ADDR_W'(A_PRIO + s / PPW)) begin
                    st_d.prio[s*PRIO_W +: PRIO_W] = wdata_i[(s % PPW)*PRIO_W +: PRIO_W];
                end
            end
        end
        if (wr_req_c) begin
            clr_c = ~wdata_i[NUM_SRC-1:0];
        end
        st_d.latch = ((st_q.latch & ~clr_c) | (evt_i & st_q.edge_mode)) & st_d.edge_mode;
    end

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            pend_o[s] = (st_q.edge_mode[s] == eirq_pkg::SENSE_EDGE) ? st_q.latch[s] : sync_i[s];
        end
    end

    assign prio_o = st_q.prio;

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_MODE) begin
            rdata_o[NUM_SRC-1:0] = st_q.edge_mode;
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (addr_i == ADDR_W'(A_PRIO + s / PPW)) begin
                rdata_o[(s % PPW)*PRIO_W +: PRIO_W] = st_q.prio[s*PRIO_W +: PRIO_W];
            end
        end
        if (addr_i == A_REQ) begin
            rdata_o[NUM_SRC-1:0] = pend_o;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    wr_one_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_c |=> ((st_q.latch & $past(st_q.latch & wdata_i[NUM_SRC-1:0]))
                      == $past(st_q.latch & wdata_i[NUM_SRC-1:0])));

    // R7
    evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|(evt_i & st_q.edge_mode)) && !wr_mode_c)
        |=> ((st_q.latch & $past(evt_i & st_q.edge_mode)) == $past(evt_i & st_q.edge_mode)));
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter #(
    parameter int unsigned NUM_SRC = eirq_pkg::EIRQ_NUM_SRC,
    parameter int unsigned PRIO_W  = eirq_pkg::EIRQ_PRIO_W,
    parameter int unsigned SRC_W   = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0] WAKE_MASK = {1'b0, {(NUM_SRC-1){1'b1}}}
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         mask_i,
    output logic                      req_o,
    output logic [PRIO_W-1:0]         lvl_o,
    output logic [SRC_W-1:0]          src_o,
    output logic                      wake_o
);
    typedef struct packed {
        logic              req;
        logic              wake;
        logic [PRIO_W-1:0] lvl;
        logic [SRC_W-1:0]  src;
    } arb_st_t;

    arb_st_t st_q, st_d;
    logic [PRIO_W-1:0] best_c;
    logic [SRC_W-1:0]  idx_c;
    logic              wake_c;

    always_comb begin
        best_c = '0;
        idx_c  = '0;
        wake_c = 1'b0;
        // walk downward with >= so that the lowest index wins a tie
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0)
                && (prio_i[i*PRIO_W +: PRIO_W] >= best_c)) begin
                best_c = prio_i[i*PRIO_W +: PRIO_W];
                idx_c  = SRC_W'(i);
            end
            if (WAKE_MASK[i] && pend_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > mask_i)) begin
                wake_c = 1'b1;
            end
        end
        st_d.req  = best_c > mask_i;
        st_d.lvl  = best_c;
        st_d.src  = idx_c;
        st_d.wake = wake_c;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.req;
    assign lvl_o  = st_q.lvl;
    assign src_o  = st_q.src;
    assign wake_o = st_q.wake;

    // R10
    req_above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.req |-> (st_q.lvl > $past(mask_i)));

    // R11
    wake_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |-> ($past(pend_i & WAKE_MASK) != '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
    parameter int unsigned NUM_SRC     = eirq_pkg::EIRQ_NUM_SRC,
    parameter int unsigned PRIO_W      = eirq_pkg::EIRQ_PRIO_W,
    parameter int unsigned DATA_W      = eirq_pkg::EIRQ_DATA_W,
    parameter int unsigned ADDR_W      = eirq_pkg::EIRQ_ADDR_W,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 2,
    parameter int unsigned SRC_W       = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] pin_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [PRIO_W-1:0]  cpu_mask_i,
    output logic               irq_req_o,
    output logic [PRIO_W-1:0]  irq_level_o,
    output logic [SRC_W-1:0]   irq_src_o,
    output logic               wake_o
);
    logic [NUM_SRC-1:0]        sync_w;
    logic [NUM_SRC-1:0]        evt_w;
    logic [NUM_SRC-1:0]        pend_w;
    logic [NUM_SRC*PRIO_W-1:0] prio_w;

    eirq_pin_qual #(
        .NUM_SRC    (NUM_SRC),
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_PULSE  (MIN_PULSE)
    ) u_qual (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pin_i),
        .sync_o(sync_w),
        .evt_o (evt_w)
    );

    eirq_regs #(
        .NUM_SRC(NUM_SRC),
        .PRIO_W (PRIO_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (reg_we_i),
        .addr_i (reg_addr_i),
        .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .sync_i (sync_w),
        .evt_i  (evt_w),
        .pend_o (pend_w),
        .prio_o (prio_w)
    );

    eirq_arbiter #(
        .NUM_SRC(NUM_SRC),
        .PRIO_W (PRIO_W),
        .SRC_W  (SRC_W)
    ) u_arb (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pend_i(pend_w),
        .prio_i(prio_w),
        .mask_i(cpu_mask_i),
        .req_o (irq_req_o),
        .lvl_o (irq_level_o),
        .src_o (irq_src_o),
        .wake_o(wake_o)
    );
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
    localparam real CLK_HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [5:0]  pin = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  mask = '0;
    logic        irq_req;
    logic [3:0]  irq_lvl;
    logic [2:0]  irq_src;
    logic        wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [15:0] rd;
        logic        req;
        logic [3:0]  lvl;
        logic [2:0]  src;
        logic        wk;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_HALF) clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .pin_i      (pin),
        .reg_we_i   (we),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .cpu_mask_i (mask),
        .irq_req_o  (irq_req),
        .irq_level_o(irq_lvl),
        .irq_src_o  (irq_src),
        .wake_o     (wake)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic exp_out(input string tag, input logic r, input logic [3:0] l,
                           input logic [2:0] s, input logic w);
        exp_t e;
        e.tag = tag; e.is_rd = 1'b0; e.rd = '0; e.req = r; e.lvl = l; e.src = s; e.wk = w;
        exp_q.push_back(e);
    endtask

    task automatic exp_rd(input string tag, input logic [1:0] a, input logic [15:0] v);
        exp_t e;
        addr = a;
        e.tag = tag; e.is_rd = 1'b1; e.rd = v; e.req = 1'b0; e.lvl = '0; e.src = '0; e.wk = 1'b0;
        exp_q.push_back(e);
    endtask

    // monitor: compares queued items just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (e.is_rd) begin
                    if (rdata !== e.rd) begin
                        n_bad++;
                        $display("FAIL %s: rdata=%h expected %h", e.tag, rdata, e.rd);
                    end
                end else if ({irq_req, irq_lvl, irq_src, wake} !== {e.req, e.lvl, e.src, e.wk}) begin
                    n_bad++;
                    $display("FAIL %s: req=%b lvl=%0d src=%0d wake=%b expected req=%b lvl=%0d src=%0d wake=%b",
                             e.tag, irq_req, irq_lvl, irq_src, wake, e.req, e.lvl, e.src, e.wk);
                end
            end
        end
    end

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_ni = 1'b1;
        step(1);
        // R1 reset state
        exp_out("R1 outputs", 0, 0, 0, 0);
        for (int a = 0; a < 4; a++) begin
            exp_rd("R1 regs", 2'(a), 16'h0000);
            step(1);
        end

        // R2 register map
        wr(0, 16'hFFC0);
        exp_rd("R2 mode bits", 0, 16'h0000);
        wr(1, 16'h4321);
        wr(2, 16'hFF65);
        exp_rd("R2 prio word1", 1, 16'h4321);
        step(1);
        exp_rd("R2 prio word2", 2, 16'h0065);

        // R3/R12 level pin 2 (prio 3)
        mask = 4'd0;
        step(1);
        pin[2] = 1'b1;
        step(2);
        exp_rd("R3 live level bit", 3, 16'h0004);
        exp_out("R12 not yet", 0, 0, 0, 0);
        step(1);
        exp_out("R12 level at 3rd edge", 1, 3, 2, 1);
        pin[2] = 1'b0;
        step(2);
        exp_rd("R3 level falls", 3, 16'h0000);
        step(1);
        exp_out("R3 no latch", 0, 0, 0, 0);

        // R9 priority
        pin = 6'b001110;
        step(3);
        exp_out("R9 highest of 1..3", 1, 4, 3, 1);
        pin = 6'b111111;
        step(3);
        exp_out("R9 all pending", 1, 6, 5, 1);
        wr(1, 16'h4361);
        step(1);
        exp_out("R9 tie lower wins", 1, 6, 1, 1);

        // R10 mask compare
        mask = 4'd6;
        step(1);
        exp_out("R10 equal mask", 0, 6, 1, 0);
        mask = 4'd5;
        step(1);
        exp_out("R10 above mask", 1, 6, 1, 1);

        // R8 zero priority masks pin 1
        wr(1, 16'h4301);
        step(1);
        exp_out("R8 prio zero", 1, 6, 5, 0);

        // R11 wake subset
        mask = 4'd0;
        pin = 6'b100000;
        step(3);
        exp_out("R11 pin5 no wake", 1, 6, 5, 0);
        pin = 6'b110000;
        step(3);
        exp_out("R11 pin4 wakes", 1, 6, 5, 1);
        mask = 4'd5;
        step(1);
        exp_out("R11 pin4 not above mask", 1, 6, 5, 0);

        // R4 edge pin 0 (prio 1)
        mask = 4'd0;
        pin = '0;
        step(3);
        exp_out("R4 idle", 0, 0, 0, 0);
        wr(0, 16'h0001);
        pin[0] = 1'b1;
        step(2);
        pin[0] = 1'b0;
        step(1);
        exp_rd("R4 not before 4th edge", 3, 16'h0000);
        step(1);
        exp_rd("R4 latched at 4th edge", 3, 16'h0001);
        exp_out("R12 edge not yet", 0, 0, 0, 0);
        step(1);
        exp_out("R12 edge at 5th edge", 1, 1, 0, 1);
        step(5);
        exp_rd("R4 held after pin low", 3, 16'h0001);

        // R6 write-one no effect, write-zero clears, level bit live
        wr(3, 16'hFFFF);
        exp_rd("R6 write one keeps", 3, 16'h0001);
        step(1);
        exp_out("R6 still requesting", 1, 1, 0, 1);
        pin[5] = 1'b1;
        step(3);
        exp_rd("R6 both bits", 3, 16'h0021);
        wr(3, 16'h0000);
        exp_rd("R6 clear edge keep level", 3, 16'h0020);
        pin[5] = 1'b0;
        step(3);
        exp_out("R6 cleared", 0, 0, 0, 0);

        // R5 one-cycle pulse rejected
        pin[0] = 1'b1;
        step(1);
        pin[0] = 1'b0;
        step(6);
        exp_rd("R5 short pulse", 3, 16'h0000);
        exp_out("R5 no request", 0, 0, 0, 0);

        // R7 new edge coincides with clear write
        pin[0] = 1'b1;
        step(3);
        pin[0] = 1'b0;
        step(3);
        exp_rd("R7 first pulse latched", 3, 16'h0001);
        step(3);
        pin[0] = 1'b1;
        step(3);
        we = 1'b1; addr = 2'd3; wdata = 16'h0000;
        step(1);
        we = 1'b0;
        exp_rd("R7 edge beats clear", 3, 16'h0001);
        wr(3, 16'h0000);
        exp_rd("R7 later clear works", 3, 16'h0000);

        step(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule